// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A character written through a one-entry holding register is moved into a shift register and sent as one low start bit, then 5 to 8 data bits, then an optional parity bit, then one or two high stop bits. A baud tick input, pulsed at sixteen times the bit rate, paces every bit. The frame format comes from a set of control inputs, and the block copies these into the shift register when a character starts.

Two status outputs let a producer pace itself. `hold_empty` shows that another character may be written. `tx_empty` shows that the line has gone quiet. A transmit-enable input stops new characters from starting, but it does not cut short the character already on the line. A break input forces the line low without disturbing the shifter's timing.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A frame is a 0 start bit, the data bits least significant first, and then stop bits at 1. Each bit lasts exactly 16 `baud_tick` pulses. Between frames `txd` rests at 1.
- R3: `fmt_len` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above that length are not sent.
- R4: When `fmt_stop2` is 0 the frame has one stop bit. When it is 1 the frame has two stop bits.
- R5: When `fmt_par_en` is 1, one parity bit follows the data, set by `fmt_par_sel`: 0 makes the count of ones in data plus parity odd, 1 makes it even, 2 sends 1 and 3 sends 0. When `fmt_par_en` is 0, no parity bit is sent.
- R6: While `brk` is 1, `txd` is 0 from the next cycle onward. The frame in progress keeps its timing, and `txd` returns to the line value once `brk` is 0.
- R7: A write (`wr_valid` = 1) clears `hold_empty` from the next cycle. `hold_empty` sets again when the shifter takes the character, which can only happen while the holding register is full.
- R8: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R9: While `tx_en` is 0, no new frame starts. A frame already started completes. A held character is sent once `tx_en` returns to 1.
- R10: A write while the holding register is full replaces the pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en | input | 1 | Allows new frames to start |
| wr_valid | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 8 | Character to send |
| fmt_len | input | 2 | Data length code (5 to 8 bits) |
| fmt_stop2 | input | 1 | Two stop bits when 1 |
| fmt_par_en | input | 1 | Adds a parity bit when 1 |
| fmt_par_sel | input | 2 | Parity kind: odd, even, forced 1, forced 0 |
| brk | input | 1 | Holds the line low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register empty and shifter idle |

## Verification
The assertions check on every cycle the properties that hold at all times: the line idles high, a break pulls it low, `tx_empty` implies `hold_empty`, a write clears `hold_empty`, no frame starts while disabled or with nothing held, and each bit boundary falls on a baud tick. The frame contents can only be shown by the bench's scenarios: bit order, the length and parity codes, the number of stop bits, a replaced pending character, and a held character that resumes after enable returns. The bench decodes the line at mid-bit points and compares it with values computed from the format.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  typedef struct packed {
    logic [1:0] len;
    logic       stop2;
    logic       par_en;
    logic [1:0] par_sel;
  } fmt_t;

  // index of the final data bit for a length code (5..8 bits)
  function automatic logic [2:0] last_data_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // mask of the data bits actually sent
  function automatic logic [7:0] data_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // parity bit for the masked character under a given selection
  function automatic logic parity_bit(input logic [7:0] d, input fmt_t f);
    logic [7:0] m;
    logic p;
    m = d & data_mask(f.len);
    case (f.par_sel)
      2'd0:    p = ~(^m);
      2'd1:    p = ^m;
      2'd2:    p = 1'b1;
      default: p = 1'b0;
    endcase
    return p;
  endfunction

  // level driven on the line for a given phase
  function automatic logic phase_level(input phase_t ph, input logic data_lsb,
                                       input logic par);
    logic v;
    case (ph)
      PH_START: v = 1'b0;
      PH_DATA:  v = data_lsb;
      PH_PAR:   v = par;
      default:  v = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr) begin
        data <= wr_data;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic tick,
  output logic bit_end
);

  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt;

  assign bit_end = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] load_data,
  input  fmt_t       load_fmt,
  input  logic       bit_end,
  output logic       busy,
  output logic       line_bit
);

  phase_t     phase;
  fmt_t       fmt_q;
  logic [7:0] sreg;
  logic [2:0] idx;
  logic       par_q;
  logic       stop_n;

  assign busy     = (phase != PH_IDLE);
  assign line_bit = phase_level(phase, sreg[0], par_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      fmt_q  <= '0;
      sreg   <= '0;
      idx    <= '0;
      par_q  <= 1'b0;
      stop_n <= 1'b0;
    end else if (start) begin
      phase  <= PH_START;
      fmt_q  <= load_fmt;
      sreg   <= load_data;
      par_q  <= parity_bit(load_data, load_fmt);
      idx    <= '0;
      stop_n <= 1'b0;
    end else if (bit_end) begin
      case (phase)
        PH_START: begin
          phase <= PH_DATA;
          idx   <= '0;
        end
        PH_DATA: begin
          sreg <= {1'b0, sreg[7:1]};
          idx  <= idx + 3'd1;
          if (idx == last_data_idx(fmt_q.len))
            phase <= fmt_q.par_en ? PH_PAR : PH_STOP;
        end
        PH_PAR: begin
          phase  <= PH_STOP;
          stop_n <= 1'b0;
        end
        PH_STOP: begin
          if (fmt_q.stop2 && !stop_n) stop_n <= 1'b1;
          else phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic line_bit,
  output logic txd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else        txd <= brk ? 1'b0 : line_bit;
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       tx_en,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] fmt_len,
  input  logic       fmt_stop2,
  input  logic       fmt_par_en,
  input  logic [1:0] fmt_par_sel,
  input  logic       brk,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);

  logic       hold_full;
  logic [7:0] hold_data;
  logic       busy;
  logic       start_evt;
  logic       bit_end;
  logic       line_bit;
  fmt_t       fmt_in;

  assign fmt_in     = '{len: fmt_len, stop2: fmt_stop2,
                        par_en: fmt_par_en, par_sel: fmt_par_sel};
  assign start_evt  = hold_full && !busy && tx_en;
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !busy;

  uart_tx_hold #(.DATA_W(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(wr_valid), .wr_data(wr_data),
    .take(start_evt), .full(hold_full), .data(hold_data)
  );

  uart_tx_bitclk #(.OSR(OSR)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(busy), .clear(start_evt),
    .tick(baud_tick), .bit_end(bit_end)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .load_data(hold_data),
    .load_fmt(fmt_in), .bit_end(bit_end), .busy(busy), .line_bit(line_bit)
  );

  uart_tx_line u_line (
    .clk(clk), .rst_n(rst_n), .brk(brk), .line_bit(line_bit), .txd(txd)
  );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_en,
  input logic wr_valid,
  input logic brk,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty,
  input logic busy,
  input logic start_evt,
  input logic bit_end
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |=> txd) else $error("idle line low"); // R2

  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> (baud_tick && busy)) else $error("bit edge without tick"); // R2

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd) else $error("break not driven"); // R6

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !hold_empty) else $error("write left holding empty"); // R7

  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !hold_empty) else $error("start with nothing held"); // R7

  AST_EMPTY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (hold_empty && !busy)) else $error("tx_empty while active"); // R8

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !start_evt) else $error("start while disabled"); // R9

endmodule

bind uart_tx_core uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
  .wr_valid(wr_valid), .brk(brk), .txd(txd), .hold_empty(hold_empty),
  .tx_empty(tx_empty), .busy(busy), .start_evt(start_evt), .bit_end(bit_end)
);

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;

  localparam int TP  = 4;          // cycles between baud ticks
  localparam int BIT = 16 * TP;    // cycles per bit
  localparam int HB  = 8 * TP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b1;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] fmt_len = 2'd3;
  logic fmt_stop2 = 1'b0;
  logic fmt_par_en = 1'b0;
  logic [1:0] fmt_par_sel = 2'd0;
  logic brk = 1'b0;
  logic txd, hold_empty, tx_empty;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  uart_tx_core u_uart_tx_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .fmt_len(fmt_len),
    .fmt_stop2(fmt_stop2), .fmt_par_en(fmt_par_en), .fmt_par_sel(fmt_par_sel),
    .brk(brk), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always @(negedge clk) begin
    tdiv <= (tdiv == TP - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TP - 1);
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] len,
                                   input logic [1:0] sel);
    int ones = 0;
    for (int i = 0; i < n_bits(len); i++) ones += d[i];
    if (sel == 2'd2) return 1'b1;
    if (sel == 2'd3) return 1'b0;
    if (sel == 2'd1) return logic'(ones % 2);
    return logic'((ones + 1) % 2);
  endfunction

  task automatic write_char(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_start();
    int n = 0;
    while (txd !== 1'b0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk("R2 start seen", 32'(txd === 1'b0), 1);
  endtask

  // decode one frame; more=1 when another character is pending
  task automatic run_frame(input logic [7:0] d, input bit more);
    wait_start();
    repeat (HB) @(negedge clk);
    chk("R2 start bit", 32'(txd), 0);
    for (int i = 0; i < n_bits(fmt_len); i++) begin
      repeat (BIT) @(negedge clk);
      chk("R2 R3 data bit", 32'(txd), 32'(d[i]));
    end
    if (fmt_par_en) begin
      repeat (BIT) @(negedge clk);
      chk("R5 parity bit", 32'(txd), 32'(exp_par(d, fmt_len, fmt_par_sel)));
    end
    repeat (BIT) @(negedge clk);
    chk("R3 R5 stop after data", 32'(txd), 1);
    chk("R8 busy in stop", 32'(tx_empty), 0);
    if (!more) begin
      repeat (BIT) @(negedge clk);
      chk("R4 line after first stop", 32'(txd), 1);
      chk("R4 stop count", 32'(tx_empty), 32'(!fmt_stop2));
      if (fmt_stop2) begin
        repeat (BIT) @(negedge clk);
        chk("R8 idle after two stops", 32'(tx_empty), 1);
      end
    end
  endtask

  initial begin
    int errs;
    int n;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 txd reset", 32'(txd), 1);
    chk("R1 hold_empty reset", 32'(hold_empty), 1);
    chk("R1 tx_empty reset", 32'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed formats
    fmt_len = 2'd3; write_char(8'hA5); run_frame(8'hA5, 0);
    fmt_len = 2'd0; fmt_par_en = 1; fmt_par_sel = 2'd0;
    write_char(8'hE3); run_frame(8'hE3, 0);
    fmt_len = 2'd1; fmt_par_sel = 2'd1; fmt_stop2 = 1;
    write_char(8'h2B); run_frame(8'h2B, 0);
    fmt_len = 2'd2; fmt_par_sel = 2'd2; write_char(8'h00); run_frame(8'h00, 0);
    fmt_par_sel = 2'd3; write_char(8'h7F); run_frame(8'h7F, 0);

    // random formats
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      d           = 8'($urandom);
      fmt_len     = 2'($urandom);
      fmt_stop2   = 1'($urandom);
      fmt_par_en  = 1'($urandom);
      fmt_par_sel = 2'($urandom);
      write_char(d);
      run_frame(d, 0);
    end

    // R10 and R7: overwrite of a pending character
    fmt_len = 2'd3; fmt_stop2 = 0; fmt_par_en = 0;
    write_char(8'h11);
    write_char(8'h22);
    chk("R7 write clears hold_empty", 32'(hold_empty), 0);
    write_char(8'h33);
    run_frame(8'h11, 1);
    chk("R7 still held during frame", 32'(hold_empty), 0);
    run_frame(8'h33, 0);
    chk("R7 hold_empty after take", 32'(hold_empty), 1);
    errs = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) errs++;
    end
    chk("R10 no extra frame", 32'(errs), 0);

    // R9: enable dropped mid-frame
    write_char(8'h5A);
    write_char(8'hC6);
    tx_en = 1'b0;
    run_frame(8'h5A, 1);
    errs = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) errs++;
    end
    chk("R9 no start while disabled", 32'(errs), 0);
    chk("R9 char still held", 32'(hold_empty), 0);
    chk("R8 not empty while held", 32'(tx_empty), 0);
    tx_en = 1'b1;
    run_frame(8'hC6, 0);

    // R6: break during a frame, timing unaffected
    write_char(8'hFF);
    n = 0;
    repeat (100) @(negedge clk);
    n += 100;
    brk = 1'b1;
    @(negedge clk);
    n++;
    chk("R6 break forces low", 32'(txd), 0);
    errs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (txd !== 1'b0) errs++;
    end
    chk("R6 held low", 32'(errs), 0);
    brk = 1'b0;
    while (!tx_empty && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 frame timing kept", 32'(n >= 10 * BIT - 8 && n <= 10 * BIT + 8), 1);
    repeat (2) @(negedge clk);
    chk("R6 line released", 32'(txd), 1);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule